// File: doc/BRIEF.md
# Dual Timer/Counter Pair

This block holds two independent timer/counters. Each is built from a low byte and a high byte register, and each can count in one of four structures. A single configuration byte gives each unit a 4-bit field. The field picks the counting structure, picks the count source (every clock, or falling edges on an external pin), and can make counting depend on the level of an external gate pin. Per-unit run inputs start and stop counting. A narrow write port lets software preload any of the four byte registers. A per-unit overflow flag goes to an interrupt controller.

The four structures are:
- a 13-bit counter;
- a 16-bit counter;
- an 8-bit counter that reloads itself from the high byte;
- a split arrangement in which unit 0's two bytes run as two separate 8-bit counters.

In the split arrangement the high byte of unit 0 borrows unit 1's run input and overflow flag. If unit 1 is given the split code, it stops counting.

All controls are plain level signals sampled on the clock. There is no streaming data path, so no valid/ready handshake is needed. A register write always takes effect in the cycle it is presented.

Top module: `tmr_dual`

## Requirements
- R1: A synchronous reset (`rst` high) clears all four count bytes, the configuration byte and both overflow flags.
- R2: With `wr_en` high, `wr_sel` picks the target byte: 0 = unit 0 low, 1 = unit 1 low, 2 = unit 0 high, 3 = unit 1 high. The byte takes `wr_data` at the next edge. A write suppresses that unit's count step in that cycle; in the split arrangement it suppresses only the written half's step.
- R3: `mode_we` loads `mode_din` into the configuration byte. Bits [3:0] configure unit 0 and bits [7:4] configure unit 1. Within each field, bits [1:0] select the structure (0 = 13-bit, 1 = 16-bit, 2 = 8-bit reload, 3 = split), bit 2 = 1 selects pin counting, and bit 3 = 1 enables gating.
- R4: A unit steps only while its run bit is 1 and either gating is off or its gate pin, after a two-flop synchronizer, is high. With run low the count holds.
- R5: In timer mode a unit steps once per clock. In counter mode it steps once per 1-to-0 transition of its count pin, seen through a two-flop synchronizer; rising edges do not count.
- R6: Structure 0 counts the value {high byte, low byte[4:0]}. Low bits [7:5] are left unchanged. Stepping from 0x1FFF wraps to zero and signals overflow.
- R7: Structure 1 counts {high, low} as 16 bits. Stepping from 0xFFFF wraps to zero and signals overflow.
- R8: Structure 2 steps the low byte alone. Stepping from 0xFF loads the high byte into the low byte, leaves the high byte unchanged and signals overflow.
- R9: When unit 0 uses structure 3, its low byte runs as an 8-bit counter under unit 0's run, gate and source controls and overflows into flag 0. Its high byte steps every clock while `run_i[1]` is high and overflows into flag 1. Overflows of unit 1 do not reach flag 1 while this holds.
- R10: When unit 1 uses structure 3, its two bytes hold their values; only writes change them.
- R11: With FLAG_HOLD = 1 (the default), an overflow sets the unit's flag in the same edge as the wrap. The flag stays set until `flag_ack_i` is high for a cycle with no new overflow; a new overflow wins over an acknowledge. With FLAG_HOLD = 0 the flag is a one-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mode_we | input | 1 | Load strobe for the configuration byte |
| mode_din | input | 8 | New configuration byte |
| wr_en | input | 1 | Count byte write strobe |
| wr_sel | input | 2 | Count byte select |
| wr_data | input | 8 | Count byte write value |
| run_i | input | 2 | Run bit per unit |
| cnt_pin_i | input | 2 | External count pin per unit (asynchronous) |
| gate_pin_i | input | 2 | External gate pin per unit (asynchronous) |
| flag_ack_i | input | 2 | Overflow flag acknowledge per unit |
| flag_o | output | 2 | Overflow flag per unit |
| tl0_o | output | 8 | Unit 0 low byte |
| th0_o | output | 8 | Unit 0 high byte |
| tl1_o | output | 8 | Unit 1 low byte |
| th1_o | output | 8 | Unit 1 high byte |

## Verification
Random timer runs use random starting bytes, random cycle counts and a random structure per unit. The result is compared against a stepping model, which separates the wrap points and carry paths of structures 0, 1 and 2, and shows whether the configuration fields are decoded per unit. Directed cases cover:
- edge values for the 13-bit wrap (bits [7:5] must survive);
- the reload wrap;
- the split arrangement, with borrowed run and flag routing and unit 1's overflow kept off flag 1;
- a held unit 1;
- gate latency;
- pin pulses, which tell falling edges from rising edges;
- a write landing during counting;
- an acknowledge coinciding with an overflow.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  typedef enum logic [1:0] {
    M_13    = 2'd0,
    M_16    = 2'd1,
    M_RLD   = 2'd2,
    M_SPLIT = 2'd3
  } tmr_mode_e;

  // field layout per unit: [3] gate enable, [2] pin count, [1:0] structure
  typedef struct packed {
    logic      gate_en;
    logic      ext_cnt;
    tmr_mode_e mode;
  } tmr_cfg_t;

  localparam int CFG_W = 4;

endpackage

// File: rtl/tmr_pin_sync.sv
module tmr_pin_sync #(
  parameter int STAGES = 2,
  parameter bit EDGE   = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_i,
  output logic sig_o
);

  logic [STAGES-1:0] sh_q;
  logic              prev_q;
  logic              lvl;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q   <= '0;
      prev_q <= 1'b0;
    end else begin
      sh_q   <= {sh_q[STAGES-2:0], pin_i};
      prev_q <= sh_q[STAGES-1];
    end
  end

  assign lvl = sh_q[STAGES-1];

  generate
    if (EDGE) begin : g_fall
      assign sig_o = prev_q & ~lvl;
      // a falling edge report can never repeat on consecutive cycles (R5)
      assert_fall_single_R5: assert property (@(posedge clk) disable iff (rst)
        sig_o |=> !sig_o);
    end else begin : g_level
      assign sig_o = lvl;
    end
  endgenerate

endmodule

// File: rtl/tmr_flag.sv
module tmr_flag #(
  parameter bit HOLD = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic ack_i,
  output logic flag_o
);

  logic flag_q;

  generate
    if (HOLD) begin : g_hold
      always_ff @(posedge clk) begin
        if (rst) flag_q <= 1'b0;
        else     flag_q <= set_i | (flag_q & ~ack_i);
      end
      assert_flag_keep_R11: assert property (@(posedge clk) disable iff (rst)
        (flag_q && !ack_i) |=> flag_q);
    end else begin : g_pulse
      always_ff @(posedge clk) begin
        if (rst) flag_q <= 1'b0;
        else     flag_q <= set_i;
      end
      assert_flag_pulse_R11: assert property (@(posedge clk) disable iff (rst)
        !set_i |=> !flag_q);
    end
  endgenerate

  assign flag_o = flag_q;

  assert_flag_set_R11: assert property (@(posedge clk) disable iff (rst)
    set_i |=> flag_q);

endmodule

// File: rtl/tmr_unit.sv
module tmr_unit
  import tmr_pkg::*;
#(
  parameter int BYTE_W   = 8,
  parameter int M0_LOW_W = 5,
  parameter bit SPLIT_OK = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  tmr_cfg_t          cfg_i,
  input  logic              run_self_i,
  input  logic              run_other_i,
  input  logic              gate_i,
  input  logic              cnt_fall_i,
  input  logic              wr_lo_i,
  input  logic              wr_hi_i,
  input  logic [BYTE_W-1:0] wr_data_i,
  output logic [BYTE_W-1:0] tl_o,
  output logic [BYTE_W-1:0] th_o,
  output logic              ovf_lo_o,
  output logic              ovf_hi_o
);

  localparam int W13 = BYTE_W + M0_LOW_W;
  localparam int W16 = 2 * BYTE_W;

  logic [BYTE_W-1:0] tl_q, th_q, tl_d, th_d;
  logic [W13-1:0]    sum13;
  logic [W16-1:0]    sum16;
  logic              tick, hi_run, wr_any;

  assign tick   = run_self_i & (~cfg_i.gate_en | gate_i) &
                  (cfg_i.ext_cnt ? cnt_fall_i : 1'b1);
  assign hi_run = run_other_i & SPLIT_OK;
  assign wr_any = wr_lo_i | wr_hi_i;

  always_comb begin
    tl_d     = tl_q;
    th_d     = th_q;
    ovf_lo_o = 1'b0;
    ovf_hi_o = 1'b0;
    sum13    = {th_q, tl_q[M0_LOW_W-1:0]} + 1'b1;
    sum16    = {th_q, tl_q} + 1'b1;
    case (cfg_i.mode)
      M_13: begin
        if (tick && !wr_any) begin
          th_d                 = sum13[W13-1:M0_LOW_W];
          tl_d[M0_LOW_W-1:0]   = sum13[M0_LOW_W-1:0];
          ovf_lo_o             = &{th_q, tl_q[M0_LOW_W-1:0]};
        end
      end
      M_16: begin
        if (tick && !wr_any) begin
          th_d     = sum16[W16-1:BYTE_W];
          tl_d     = sum16[BYTE_W-1:0];
          ovf_lo_o = &{th_q, tl_q};
        end
      end
      M_RLD: begin
        if (tick && !wr_any) begin
          if (&tl_q) begin
            tl_d     = th_q;
            ovf_lo_o = 1'b1;
          end else begin
            tl_d = tl_q + 1'b1;
          end
        end
      end
      default: begin
        if (SPLIT_OK) begin
          if (tick && !wr_lo_i) begin
            tl_d     = tl_q + 1'b1;
            ovf_lo_o = &tl_q;
          end
          if (hi_run && !wr_hi_i) begin
            th_d     = th_q + 1'b1;
            ovf_hi_o = &th_q;
          end
        end
      end
    endcase
    if (wr_lo_i) tl_d = wr_data_i;
    if (wr_hi_i) th_d = wr_data_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tl_q <= '0;
      th_q <= '0;
    end else begin
      tl_q <= tl_d;
      th_q <= th_d;
    end
  end

  assign tl_o = tl_q;
  assign th_o = th_q;

  assert_wr_lo_R2: assert property (@(posedge clk) disable iff (rst)
    wr_lo_i |=> tl_q == $past(wr_data_i));
  assert_wr_hi_R2: assert property (@(posedge clk) disable iff (rst)
    wr_hi_i |=> th_q == $past(wr_data_i));
  assert_stop_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (!run_self_i && cfg_i.mode != M_SPLIT && !wr_any) |=>
      ($stable(tl_q) && $stable(th_q)));
  assert_m16_step_R7: assert property (@(posedge clk) disable iff (rst)
    (cfg_i.mode == M_16 && !cfg_i.ext_cnt && !cfg_i.gate_en && run_self_i && !wr_any) |=>
      {th_q, tl_q} == $past({th_q, tl_q}) + 1'b1);
  assert_reload_R8: assert property (@(posedge clk) disable iff (rst)
    (cfg_i.mode == M_RLD && tick && (&tl_q) && !wr_any) |=>
      (tl_q == $past(th_q) && $stable(th_q)));

  generate
    if (!SPLIT_OK) begin : g_nosplit
      assert_split_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (cfg_i.mode == M_SPLIT && !wr_any) |=> ($stable(tl_q) && $stable(th_q)));
    end
  endgenerate

endmodule

// File: rtl/tmr_dual.sv
module tmr_dual
  import tmr_pkg::*;
#(
  parameter int BYTE_W      = 8,
  parameter int M0_LOW_W    = 5,
  parameter int SYNC_STAGES = 2,
  parameter bit FLAG_HOLD   = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mode_we,
  input  logic [7:0]        mode_din,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic [1:0]        run_i,
  input  logic [1:0]        cnt_pin_i,
  input  logic [1:0]        gate_pin_i,
  input  logic [1:0]        flag_ack_i,
  output logic [1:0]        flag_o,
  output logic [BYTE_W-1:0] tl0_o,
  output logic [BYTE_W-1:0] th0_o,
  output logic [BYTE_W-1:0] tl1_o,
  output logic [BYTE_W-1:0] th1_o
);

  localparam int NU = 2;

  logic [NU*CFG_W-1:0] mode_q;
  tmr_cfg_t            cfg    [NU];
  logic [NU-1:0]       gate_s, fall_s, wr_lo, wr_hi, ovf_lo, ovf_hi, flag_set;
  logic [BYTE_W-1:0]   tl     [NU];
  logic [BYTE_W-1:0]   th     [NU];
  logic                split0;

  always_ff @(posedge clk) begin
    if (rst)          mode_q <= '0;
    else if (mode_we) mode_q <= mode_din;
  end

  generate
    for (genvar u = 0; u < NU; u++) begin : g_unit
      assign cfg[u]   = tmr_cfg_t'(mode_q[u*CFG_W +: CFG_W]);
      assign wr_lo[u] = wr_en && !wr_sel[1] && (wr_sel[0] == u[0]);
      assign wr_hi[u] = wr_en &&  wr_sel[1] && (wr_sel[0] == u[0]);

      tmr_pin_sync #(.STAGES(SYNC_STAGES), .EDGE(1'b1)) u_cnt_sync (
        .clk(clk), .rst(rst), .pin_i(cnt_pin_i[u]), .sig_o(fall_s[u]));
      tmr_pin_sync #(.STAGES(SYNC_STAGES), .EDGE(1'b0)) u_gate_sync (
        .clk(clk), .rst(rst), .pin_i(gate_pin_i[u]), .sig_o(gate_s[u]));

      tmr_unit #(.BYTE_W(BYTE_W), .M0_LOW_W(M0_LOW_W), .SPLIT_OK(u == 0)) u_unit (
        .clk(clk), .rst(rst), .cfg_i(cfg[u]),
        .run_self_i(run_i[u]), .run_other_i(run_i[NU-1-u]),
        .gate_i(gate_s[u]), .cnt_fall_i(fall_s[u]),
        .wr_lo_i(wr_lo[u]), .wr_hi_i(wr_hi[u]), .wr_data_i(wr_data),
        .tl_o(tl[u]), .th_o(th[u]),
        .ovf_lo_o(ovf_lo[u]), .ovf_hi_o(ovf_hi[u]));

      tmr_flag #(.HOLD(FLAG_HOLD)) u_flag (
        .clk(clk), .rst(rst), .set_i(flag_set[u]), .ack_i(flag_ack_i[u]),
        .flag_o(flag_o[u]));
    end
  endgenerate

  assign split0      = (cfg[0].mode == M_SPLIT);
  assign flag_set[0] = ovf_lo[0];
  assign flag_set[1] = split0 ? ovf_hi[0] : (ovf_lo[1] | ovf_hi[1]);

  assign tl0_o = tl[0];
  assign th0_o = th[0];
  assign tl1_o = tl[1];
  assign th1_o = th[1];

  assert_mode_load_R3: assert property (@(posedge clk) disable iff (rst)
    mode_we |=> mode_q == $past(mode_din));
  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (mode_q == '0 && flag_o == 2'b00 && tl0_o == '0 && th1_o == '0));
  assert_split_route_R9: assert property (@(posedge clk) disable iff (rst)
    (split0 && !ovf_hi[0] && FLAG_HOLD && !flag_o[1]) |=> !flag_o[1]);

endmodule

// File: tb/tmr_dual_bench.sv
`timescale 1ns/1ps
module tmr_dual_bench;

  logic       clk = 1'b0;
  logic       rst;
  logic       mode_we;
  logic [7:0] mode_din;
  logic       wr_en;
  logic [1:0] wr_sel;
  logic [7:0] wr_data;
  logic [1:0] run_i, cnt_pin_i, gate_pin_i, flag_ack_i, flag_o;
  logic [7:0] tl0_o, th0_o, tl1_o, th1_o;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  tmr_dual u_tmr_dual (
    .clk(clk), .rst(rst), .mode_we(mode_we), .mode_din(mode_din),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data), .run_i(run_i),
    .cnt_pin_i(cnt_pin_i), .gate_pin_i(gate_pin_i), .flag_ack_i(flag_ack_i),
    .flag_o(flag_o), .tl0_o(tl0_o), .th0_o(th0_o), .tl1_o(tl1_o), .th1_o(th1_o));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] sel, input logic [7:0] d);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    cyc(1);
    wr_en = 1'b0;
  endtask

  task automatic setmode(input logic [7:0] m);
    mode_we = 1'b1; mode_din = m;
    cyc(1);
    mode_we = 1'b0;
  endtask

  task automatic ack_all();
    flag_ack_i = 2'b11;
    cyc(1);
    flag_ack_i = 2'b00;
  endtask

  task automatic load4(input logic [7:0] a0, b0, a1, b1);
    wr(2'd0, a0); wr(2'd2, b0); wr(2'd1, a1); wr(2'd3, b1);
  endtask

  // returns {overflowed, high, low} after n steps of structure m
  function automatic logic [16:0] model(input logic [1:0] m, input logic [7:0] tl,
                                        input logic [7:0] th, input int n);
    logic        o;
    logic [12:0] v13;
    logic [15:0] v16;
    o = 1'b0;
    for (int i = 0; i < n; i++) begin
      case (m)
        2'd0: begin
          v13 = {th, tl[4:0]};
          if (v13 == 13'h1FFF) o = 1'b1;
          v13 = v13 + 1'b1;
          th = v13[12:5];
          tl = {tl[7:5], v13[4:0]};
        end
        2'd1: begin
          v16 = {th, tl};
          if (v16 == 16'hFFFF) o = 1'b1;
          v16 = v16 + 1'b1;
          {th, tl} = v16;
        end
        default: begin
          if (tl == 8'hFF) begin tl = th; o = 1'b1; end
          else tl = tl + 1'b1;
        end
      endcase
    end
    return {o, th, tl};
  endfunction

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [16:0] e0, e1;
    logic [7:0]  a0, b0, a1, b1;
    logic [1:0]  m0, m1;
    int          n;
    void'($urandom(32'd4242));
    rst = 1'b1; mode_we = 0; mode_din = 0; wr_en = 0; wr_sel = 0; wr_data = 0;
    run_i = 0; cnt_pin_i = 0; gate_pin_i = 0; flag_ack_i = 0;
    cyc(3);
    rst = 1'b0;
    cyc(1);
    // R1 reset state
    chk("R1 reset bytes", {tl0_o, th0_o, tl1_o, th1_o}, 32'h0);
    chk("R1 reset flags", flag_o, 2'b00);

    // R2 write select codes
    load4(8'h11, 8'h22, 8'h33, 8'h44);
    chk("R2 write map", {tl0_o, th0_o, tl1_o, th1_o}, 32'h11223344);

    // R3 R5 R6 R7 R8 random timer runs, independent structures per unit
    for (int it = 0; it < 14; it++) begin
      m0 = 2'($urandom_range(0, 2)); m1 = 2'($urandom_range(0, 2));
      a0 = 8'($urandom); b0 = 8'($urandom); a1 = 8'($urandom); b1 = 8'($urandom);
      if (it < 3) begin b0 = 8'hFF; a0 = 8'hF0; end
      n  = $urandom_range(1, 700);
      load4(a0, b0, a1, b1);
      setmode({2'b00, m1, 2'b00, m0});
      ack_all();
      run_i = 2'b11; cyc(n); run_i = 2'b00;
      e0 = model(m0, a0, b0, n);
      e1 = model(m1, a1, b1, n);
      chk("R3/R5/R6/R7/R8 unit0 count", {th0_o, tl0_o}, {16'h0, e0[15:0]});
      chk("R3/R5/R6/R7/R8 unit1 count", {th1_o, tl1_o}, {16'h0, e1[15:0]});
      chk("R11 flags after random run", flag_o, {e1[16], e0[16]});
    end

    // R4 run low holds
    setmode(8'h11);
    load4(8'h05, 8'h06, 8'h07, 8'h08);
    cyc(20);
    chk("R4 run low holds", {tl0_o, th0_o, tl1_o, th1_o}, 32'h05060708);

    // R4 gating: gate low blocks, gate high counts after two sync flops
    setmode(8'h09);
    load4(8'h00, 8'h00, 8'h00, 8'h00);
    run_i = 2'b01; cyc(30);
    chk("R4 gate low blocks", tl0_o, 8'h00);
    gate_pin_i = 2'b01; cyc(20); run_i = 2'b00;
    chk("R4 gate high counts", tl0_o, 8'd18);
    gate_pin_i = 2'b00; cyc(4);

    // R5 pin counting on falling edges only
    setmode(8'h55);
    load4(8'h00, 8'h00, 8'h00, 8'h00);
    run_i = 2'b11;
    for (int i = 0; i < 5; i++) begin
      cnt_pin_i = {(i < 3), 1'b1}; cyc(3);
      cnt_pin_i = 2'b00; cyc(3);
    end
    cnt_pin_i = 2'b11; cyc(6);
    chk("R5 unit0 pin count", tl0_o, 8'd5);
    chk("R5 unit1 pin count", tl1_o, 8'd3);
    run_i = 2'b00; cnt_pin_i = 2'b00; cyc(6);

    // R2 write wins over a step
    setmode(8'h01);
    load4(8'h10, 8'h00, 8'h00, 8'h00);
    run_i = 2'b01; cyc(3);
    chk("R7 timer steps", tl0_o, 8'h13);
    wr(2'd0, 8'h40);
    chk("R2 write beats step", tl0_o, 8'h40);
    cyc(1);
    chk("R2 count resumes", tl0_o, 8'h41);
    run_i = 2'b00;

    // R6 13-bit wrap keeps low bits [7:5]
    setmode(8'h00);
    load4(8'hFF, 8'hFF, 8'h00, 8'h00);
    ack_all();
    run_i = 2'b01; cyc(1); run_i = 2'b00;
    chk("R6 wrap bytes", {th0_o, tl0_o}, 32'h00E0);
    chk("R6 wrap flag", flag_o, 2'b01);

    // R8 reload on unit 1
    setmode(8'h20);
    load4(8'h00, 8'h00, 8'hFF, 8'h80);
    ack_all();
    run_i = 2'b10; cyc(1); run_i = 2'b00;
    chk("R8 reload bytes", {th1_o, tl1_o}, 32'h8080);
    chk("R8 reload flag", flag_o, 2'b10);

    // R9 split arrangement
    setmode(8'h13);
    load4(8'hFE, 8'hFE, 8'h00, 8'h00);
    ack_all();
    run_i = 2'b11; cyc(2); run_i = 2'b00;
    chk("R9 split bytes", {tl0_o, th0_o, tl1_o}, 32'h000002);
    chk("R9 split flags", flag_o, 2'b11);
    wr(2'd2, 8'h10); wr(2'd1, 8'hFF); wr(2'd3, 8'hFF);
    ack_all();
    run_i = 2'b10; cyc(1); run_i = 2'b00;
    chk("R9 borrowed run", {tl0_o, th0_o, tl1_o, th1_o}, 32'h00110000);
    chk("R9 unit1 overflow kept off flag", flag_o, 2'b00);

    // R10 unit 1 split code holds
    setmode(8'h31);
    load4(8'h00, 8'h00, 8'h55, 8'hAA);
    run_i = 2'b11; cyc(10); run_i = 2'b00;
    chk("R10 unit1 holds", {tl1_o, th1_o}, 32'h55AA);

    // R11 overflow beats acknowledge, then acknowledge clears
    setmode(8'h01);
    load4(8'hFF, 8'hFF, 8'h00, 8'h00);
    ack_all();
    flag_ack_i = 2'b01; run_i = 2'b01; cyc(1); run_i = 2'b00;
    chk("R11 set beats ack", flag_o[0], 1'b1);
    cyc(1); flag_ack_i = 2'b00;
    chk("R11 ack clears", flag_o[0], 1'b0);
    load4(8'hFF, 8'hFF, 8'h00, 8'h00);
    run_i = 2'b01; cyc(1); run_i = 2'b00; cyc(5);
    chk("R11 flag held", flag_o[0], 1'b1);

    // R1 reset after activity
    setmode(8'h11);
    load4(8'h12, 8'h34, 8'h56, 8'h78);
    run_i = 2'b11; cyc(7);
    rst = 1'b1; cyc(1); rst = 1'b0; run_i = 2'b00;
    chk("R1 reset bytes later", {tl0_o, th0_o, tl1_o, th1_o}, 32'h0);
    chk("R1 reset flags later", flag_o, 2'b00);
    run_i = 2'b01; cyc(3); run_i = 2'b00;
    chk("R1 configuration cleared to 13-bit", {th0_o, tl0_o}, 32'h0003);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule